// File: doc/BRIEF.md
# Time-Redundant Execution Controller with Early Abort

This controller sits next to a reconfigurable compute array and makes a kernel's results tolerant of soft errors. It does this by repeating the kernel in time rather than by adding copies of the hardware. On a host start it launches the kernel and stores every output of the first run in a result buffer. It then launches the kernel a second time with the same inputs and compares each new output, in order, against the stored one. If the whole second run agrees, the job completes after two runs.

At the first disagreement the controller does not wait for the second run to finish. It stops that run at once with a one-cycle abort pulse to the array. It then launches a third complete run and settles each element still in doubt by a vote. Elements that agreed before the disagreement keep their first-run value. The host reads the final results through an address/data port. The host also reads a status code and the number of cycles the job took.

The number of outputs per job is given by `num_out` when the job starts. It must be between 1 and DEPTH.

Top module: `retry_exec_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, `done`, `arr_launch` and `arr_abort` are 0, `status` is 0 and `cycle_count` is 0.
- R2: After `start`, `arr_launch` pulses high in the first cycle of the first run. Once `num_out` valid outputs have arrived, the first run ends and `arr_launch` pulses again to begin the second run.
- R3: If every second-run output equals the stored first-run output, the job completes with no abort and no third launch. `done` rises, `status` is 0 (clean) and each result equals its first-run value. With one output per cycle, `cycle_count` is 2·N+2 for N outputs.
- R4: When second-run output m differs from the stored value, `arr_abort` is high for exactly the one cycle after that output, and `arr_launch` is high in the cycle after the abort. With one output per cycle, the job takes 2·N+m+5 cycles, which saves the remaining second-run cycles.
- R5: Results at indices below the mismatch index m keep their first-run values. Third-run outputs at those indices have no effect.
- R6: At index m the result is the third-run value whenever the third run equals either the first or the second run. If all three differ, the third-run value is kept and the job is uncorrectable.
- R7: At indices above m the result is the first-run value when the first and third runs agree. Otherwise it is the third-run value and the job is uncorrectable.
- R8: `status` encodes 0 = clean, 1 = corrected (a mismatch occurred and every element had a majority), 2 = uncorrectable. The value 3 never appears.
- R9: `arr_launch` is always a single-cycle pulse. Once `done` is high, `done`, `status` and `cycle_count` hold until the next `start`.
- R10: `arr_valid` is ignored outside the three runs (during the abort cycle and while done). Outputs that arrive then do not change results, status or cycle count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (accepted when idle or done) |
| num_out | input | AW+1 | Number of outputs the kernel produces, 1..DEPTH |
| done | output | 1 | Job complete; results and status valid |
| status | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| cycle_count | output | CNT_W | Cycles spent in runs and abort for the last job |
| arr_launch | output | 1 | One-cycle pulse: array starts a kernel run |
| arr_abort | output | 1 | One-cycle pulse: array terminates the current run |
| arr_valid | input | 1 | Array output valid |
| arr_data | input | DATA_W | Array output word |
| res_addr | input | AW | Result read address |
| res_data | output | DATA_W | Final result at `res_addr` |

## Verification
The bench models the array with a deterministic output sequence and injects errors into chosen index ranges of chosen runs. It sweeps the mismatch position across every index of the job and tries five patterns at each position:
- an error only in the second run, which should be corrected;
- an error only in the first run, where the second and third runs outvote the stored word;
- three distinct values at the mismatch index, which cannot be corrected;
- a first-run error that persists to the end, which separates the at-index vote from the after-index vote;
- a third-run error below the mismatch index, which must be ignored.

Clean jobs at lengths 1, 6 and 8, runs with gaps between outputs, and stray outputs while done separate early abort, cycle accounting and input gating.

// File: rtl/retry_exec_pkg.sv
package retry_exec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN1  = 3'd1,
        ST_RUN2  = 3'd2,
        ST_ABORT = 3'd3,
        ST_RUN3  = 3'd4,
        ST_DONE  = 3'd5
    } exec_state_e;

    typedef enum logic [1:0] {
        RES_CLEAN     = 2'd0,
        RES_FIXED     = 2'd1,
        RES_UNFIXABLE = 2'd2
    } result_e;

    typedef enum logic [1:0] {
        POS_BEFORE = 2'd0,
        POS_AT     = 2'd1,
        POS_AFTER  = 2'd2
    } vote_pos_e;

    typedef struct packed {
        logic wr;
        logic unc;
    } vote_flags_t;

    function automatic logic is_busy(exec_state_e s);
        return (s == ST_RUN1) || (s == ST_RUN2) || (s == ST_ABORT) || (s == ST_RUN3);
    endfunction

    function automatic logic can_start(exec_state_e s);
        return (s == ST_IDLE) || (s == ST_DONE);
    endfunction

endpackage

// File: rtl/retry_exec_buf.sv
module retry_exec_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/retry_exec_vote.sv
module retry_exec_vote
    import retry_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AW     = 6
) (
    input  logic [AW-1:0]     idx,
    input  logic [AW-1:0]     mm_idx,
    input  logic [DATA_W-1:0] first_val,
    input  logic [DATA_W-1:0] second_val,
    input  logic [DATA_W-1:0] third_val,
    output vote_flags_t       flags
);
    vote_pos_e pos;

    always_comb begin
        if (idx < mm_idx)       pos = POS_BEFORE;
        else if (idx == mm_idx) pos = POS_AT;
        else                    pos = POS_AFTER;
    end

    always_comb begin
        flags = '0;
        unique case (pos)
            POS_BEFORE: flags = '0;
            POS_AT: begin
                flags.wr  = 1'b1;
                flags.unc = (third_val != first_val) && (third_val != second_val);
            end
            POS_AFTER: begin
                flags.wr  = (third_val != first_val);
                flags.unc = (third_val != first_val);
            end
            default: flags = '0;
        endcase
    end
endmodule

// File: rtl/retry_exec_cycles.sv
module retry_exec_cycles #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/retry_exec_fsm.sv
module retry_exec_fsm
    import retry_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW:0]       num_out,
    input  logic              arr_valid,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              data_ne,
    input  logic              vote_unc,
    output exec_state_e       state,
    output logic [AW-1:0]     idx,
    output logic [AW-1:0]     mm_idx,
    output logic [DATA_W-1:0] mm_val,
    output logic              launch,
    output logic              mism,
    output logic              unc,
    output logic              clr
);
    logic [AW:0] n_q;
    logic        last;

    assign last = ({1'b0, idx} == (n_q - 1'b1));
    assign clr  = can_start(state) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            mm_idx <= '0;
            mm_val <= '0;
            launch <= 1'b0;
            mism   <= 1'b0;
            unc    <= 1'b0;
            n_q    <= '0;
        end else begin
            launch <= 1'b0;
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state  <= ST_RUN1;
                        idx    <= '0;
                        mism   <= 1'b0;
                        unc    <= 1'b0;
                        mm_idx <= '0;
                        n_q    <= num_out;
                        launch <= 1'b1;
                    end
                end
                ST_RUN1: begin
                    if (arr_valid) begin
                        if (last) begin
                            state  <= ST_RUN2;
                            idx    <= '0;
                            launch <= 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_RUN2: begin
                    if (arr_valid) begin
                        if (data_ne) begin
                            mm_idx <= idx;
                            mm_val <= arr_data;
                            mism   <= 1'b1;
                            idx    <= '0;
                            state  <= ST_ABORT;
                        end else if (last) begin
                            state <= ST_DONE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_ABORT: begin
                    state  <= ST_RUN3;
                    launch <= 1'b1;
                end
                ST_RUN3: begin
                    if (arr_valid) begin
                        if (vote_unc) unc <= 1'b1;
                        if (last) state <= ST_DONE;
                        else      idx   <= idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/retry_exec_ctrl.sv
module retry_exec_ctrl
    import retry_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    parameter int CNT_W  = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW:0]       num_out,
    output logic              done,
    output logic [1:0]        status,
    output logic [CNT_W-1:0]  cycle_count,
    output logic              arr_launch,
    output logic              arr_abort,
    input  logic              arr_valid,
    input  logic [DATA_W-1:0] arr_data,
    input  logic [AW-1:0]     res_addr,
    output logic [DATA_W-1:0] res_data
);
    exec_state_e       state;
    logic [AW-1:0]     idx;
    logic [AW-1:0]     mm_idx;
    logic [DATA_W-1:0] mm_val;
    logic [DATA_W-1:0] stored;
    logic              launch;
    logic              mism;
    logic              unc;
    logic              clr;
    logic              data_ne;
    logic              buf_we;
    logic [DATA_W-1:0] buf_wd;
    vote_flags_t       vflags;
    logic              vote_unc;
    result_e           res_code;

    assign data_ne  = (arr_data != stored);
    assign vote_unc = vflags.unc;

    retry_exec_fsm #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .num_out  (num_out),
        .arr_valid(arr_valid),
        .arr_data (arr_data),
        .data_ne  (data_ne),
        .vote_unc (vote_unc),
        .state    (state),
        .idx      (idx),
        .mm_idx   (mm_idx),
        .mm_val   (mm_val),
        .launch   (launch),
        .mism     (mism),
        .unc      (unc),
        .clr      (clr)
    );

    retry_exec_vote #(.DATA_W(DATA_W), .AW(AW)) vote_i (
        .idx       (idx),
        .mm_idx    (mm_idx),
        .first_val (stored),
        .second_val(mm_val),
        .third_val (arr_data),
        .flags     (vflags)
    );

    always_comb begin
        buf_we = 1'b0;
        buf_wd = arr_data;
        if (arr_valid) begin
            if (state == ST_RUN1)      buf_we = 1'b1;
            else if (state == ST_RUN3) buf_we = vflags.wr;
        end
    end

    retry_exec_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) buf_i (
        .clk    (clk),
        .we     (buf_we),
        .waddr  (idx),
        .wdata  (buf_wd),
        .raddr_a(idx),
        .rdata_a(stored),
        .raddr_b(res_addr),
        .rdata_b(res_data)
    );

    retry_exec_cycles #(.CNT_W(CNT_W)) cyc_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .inc  (is_busy(state)),
        .count(cycle_count)
    );

    always_comb begin
        if (!mism)    res_code = RES_CLEAN;
        else if (unc) res_code = RES_UNFIXABLE;
        else          res_code = RES_FIXED;
    end

    assign status     = res_code;
    assign done       = (state == ST_DONE);
    assign arr_launch = launch;
    assign arr_abort  = (state == ST_ABORT);
endmodule

// File: rtl/retry_exec_chk.sv
module retry_exec_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             done,
    input logic [1:0]       status,
    input logic [CNT_W-1:0] cycle_count,
    input logic             arr_launch,
    input logic             arr_abort
);
    assert_abort_single_R4: assert property (@(posedge clk) disable iff (rst)
        arr_abort |=> !arr_abort);

    assert_abort_then_launch_R4: assert property (@(posedge clk) disable iff (rst)
        arr_abort |=> arr_launch);

    assert_launch_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        arr_launch |=> !arr_launch);

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(cycle_count) && $stable(status)));

    assert_done_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (!arr_abort && !arr_launch));

    assert_status_legal_R8: assert property (@(posedge clk) disable iff (rst)
        status != 2'd3);
endmodule

bind retry_exec_ctrl retry_exec_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .done       (done),
    .status     (status),
    .cycle_count(cycle_count),
    .arr_launch (arr_launch),
    .arr_abort  (arr_abort)
);

// File: tb/retry_exec_ctrl_tb_top.sv
`timescale 1ns/1ps
module retry_exec_ctrl_tb_top;
    localparam int DW    = 32;
    localparam int DEP   = 8;
    localparam int CW    = 32;
    localparam int AW    = $clog2(DEP);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW:0]   num_out = '0;
    logic          done;
    logic [1:0]    status;
    logic [CW-1:0] cycle_count;
    logic          arr_launch;
    logic          arr_abort;
    logic          arr_valid;
    logic [DW-1:0] arr_data;
    logic [AW-1:0] res_addr = '0;
    logic [DW-1:0] res_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    // array model configuration
    int n_cfg = 1;
    int gap_cfg = 0;
    int lo [1:3];
    int hi [1:3];
    logic stray_v = 1'b0;
    logic [DW-1:0] stray_d = '0;

    logic          m_valid;
    logic [DW-1:0] m_data;
    int            m_run, m_k;
    bit            m_active, m_ph;
    int            launch_cnt = 0, abort_cnt = 0;

    function automatic logic [DW-1:0] val(int r, int k);
        logic [DW-1:0] b;
        b = (32'h5A00_0000 + k * 32'h0101_0013) ^ 32'h0033_C0DE;
        if (k >= lo[r] && k <= hi[r]) b = b ^ (32'h1 << (r * 4));
        return b;
    endfunction

    always @(posedge clk) begin
        if (arr_launch) launch_cnt <= launch_cnt + 1;
        if (arr_abort)  abort_cnt  <= abort_cnt + 1;
        if (rst) begin
            m_active <= 0; m_valid <= 0; m_run <= 0; m_k <= 0; m_ph <= 0;
        end else if (start) begin
            m_run <= 0; m_active <= 0; m_valid <= 0;
        end else if (arr_abort) begin
            m_active <= 0; m_valid <= 0;
        end else if (arr_launch) begin
            m_run <= m_run + 1;
            if (gap_cfg == 0) begin
                m_valid  <= 1;
                m_data   <= val(m_run + 1, 0);
                m_k      <= 1;
                m_active <= (n_cfg > 1);
            end else begin
                m_valid  <= 0;
                m_k      <= 0;
                m_ph     <= 1;
                m_active <= 1;
            end
        end else if (m_active) begin
            if (gap_cfg == 0 || m_ph) begin
                m_valid <= 1;
                m_data  <= val(m_run, m_k);
                m_k     <= m_k + 1;
                m_ph    <= 0;
                if (m_k == n_cfg - 1) m_active <= 0;
            end else begin
                m_valid <= 0;
                m_ph    <= 1;
            end
        end else begin
            m_valid <= 0;
        end
    end

    assign arr_valid = m_valid | stray_v;
    assign arr_data  = stray_v ? stray_d : m_data;

    retry_exec_ctrl #(.DATA_W(DW), .DEPTH(DEP), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .num_out(num_out),
        .done(done), .status(status), .cycle_count(cycle_count),
        .arr_launch(arr_launch), .arr_abort(arr_abort),
        .arr_valid(arr_valid), .arr_data(arr_data),
        .res_addr(res_addr), .res_data(res_data)
    );

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #750000;
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic job(int n, int g, int l1, int h1, int l2, int h2, int l3, int h3);
        int l0, a0, m, exp_cnt, exp_st, got;
        logic [DW-1:0] v1, v2, v3, e;
        bit bad;
        n_cfg = n; gap_cfg = g;
        lo[1] = l1; hi[1] = h1; lo[2] = l2; hi[2] = h2; lo[3] = l3; hi[3] = h3;
        @(negedge clk);
        l0 = launch_cnt; a0 = abort_cnt;
        start = 1; num_out = n[AW:0];
        @(negedge clk);
        start = 0;
        got = 0;
        for (int c = 0; c < 2000; c++) begin
            @(negedge clk);
            if (done) begin got = 1; break; end
        end
        check("R2 done reached", got, 1);
        m = -1;
        for (int k = 0; k < n; k++)
            if (m < 0 && val(1, k) != val(2, k)) m = k;
        bad = 0;
        exp_st = (m < 0) ? 0 : 1;
        for (int k = 0; k < n; k++) begin
            v1 = val(1, k); v2 = val(2, k); v3 = val(3, k);
            if (m < 0 || k < m) e = v1;
            else if (k == m) begin
                e = v3;
                if (v3 != v1 && v3 != v2) bad = 1;
            end else begin
                e = v3;
                if (v3 != v1) bad = 1;
            end
            res_addr = k[AW-1:0];
            #1;
            if (m < 0)       check("R3 clean result", res_data, e);
            else if (k < m)  check("R5 pre-mismatch result", res_data, e);
            else if (k == m) check("R6 vote at mismatch", res_data, e);
            else             check("R7 vote after mismatch", res_data, e);
        end
        if (bad) exp_st = 2;
        check("R8 status code", status, exp_st);
        check("R4 launch count", launch_cnt - l0, (m < 0) ? 2 : 3);
        check("R4 abort count", abort_cnt - a0, (m < 0) ? 0 : 1);
        if (g == 0) begin
            exp_cnt = (m < 0) ? 2 * n + 2 : 2 * n + m + 5;
            if (m < 0) check("R3 cycle count clean", cycle_count, exp_cnt);
            else       check("R4 cycle count aborted", cycle_count, exp_cnt);
        end
    endtask

    initial begin
        int cnt_keep;
        logic [1:0] st_keep;
        logic [DW-1:0] d0;
        lo[1] = 99; hi[1] = -1; lo[2] = 99; hi[2] = -1; lo[3] = 99; hi[3] = -1;
        repeat (3) @(negedge clk);
        check("R1 reset done", done, 0);
        check("R1 reset launch", arr_launch, 0);
        check("R1 reset abort", arr_abort, 0);
        check("R1 reset count", cycle_count, 0);
        rst = 0;
        @(negedge clk);
        check("R1 after reset done", done, 0);
        check("R1 after reset status", status, 0);
        check("R1 after reset launch", arr_launch, 0);

        job(6, 0, 99, -1, 99, -1, 99, -1);
        job(6, 1, 99, -1, 99, -1, 99, -1);
        job(1, 0, 99, -1, 99, -1, 99, -1);
        job(8, 0, 99, -1, 99, -1, 99, -1);
        for (int m = 0; m < 6; m++) begin
            job(6, m % 2, 99, -1, m, m, 99, -1);
            job(6, (m + 1) % 2, m, m, 99, -1, 99, -1);
            job(6, m % 2, m, m, 99, -1, m, m);
            job(6, 0, m, 99, 99, -1, 99, -1);
            if (m > 0) job(6, 0, 99, -1, m, m, 0, m - 1);
        end
        job(8, 0, 99, -1, 7, 7, 99, -1);
        job(1, 0, 0, 0, 99, -1, 99, -1);
        job(8, 1, 3, 5, 99, -1, 4, 4);

        // R10: stray outputs while done
        res_addr = '0;
        #1;
        d0 = res_data;
        cnt_keep = cycle_count;
        st_keep = status;
        @(negedge clk);
        stray_v = 1; stray_d = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        stray_v = 0;
        @(negedge clk);
        res_addr = '0;
        #1;
        check("R10 stray result", res_data, d0);
        check("R10 stray count", cycle_count, cnt_keep);
        check("R10 stray status", status, st_keep);
        check("R9 done held", done, 1);

        summary();
    end
endmodule